// File: doc/BRIEF.md
# Unaligned Load/Store Access Splitter

This block sits between the load/store side of a processor and a memory bus that only moves whole, word-aligned 32-bit words. The processor may ask for a byte, a halfword or a word at any byte address. If every byte of the item falls within one aligned word, the block issues a single bus access and drives byte enables for just those lanes. If the item straddles a word boundary, the block issues two aligned accesses back to back: the lower word first, then the next word.

For stores, the block shifts the data into the right byte lanes of each beat. For loads, it keeps the lanes returned by the first beat in a holding register. After the last beat it merges them with the new lanes and shifts the result down so the item is right-justified. An optional signed flag sign-extends byte and halfword loads. A bus error on either beat is passed back with the response. A store whose first beat fails does not issue its second beat.

Both sides use a valid/ready request handshake. Each request gets one response pulse, and only one request is in flight at a time.

Top module: `lsu_split_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `reqReady` is 1, `busValid` is 0 and `rspValid` is 0.
- R2: A request whose bytes lie in one aligned word produces exactly one bus access. Its address is the request address with bits [1:0] cleared. `busBe` bit i is set exactly for the byte lanes i (lane i = bits 8i+7:8i) that the item covers.
- R3: A request whose bytes span two words produces exactly two bus accesses. The first goes to the lower aligned word and the second to that word plus 4. Each beat enables only the lanes of the item that fall in its word.
- R4: Size code 0 = byte, 1 = halfword, 2 = word. A byte never splits, a halfword splits only at byte offset 3, and a word splits at every nonzero offset.
- R5: Data is little-endian on stores. Byte k of `reqWdata` (bits 8k+7:8k) is written to byte address `reqAddr`+k. No other memory byte changes.
- R6: With `reqSigned` = 0, a load returns the byte at `reqAddr`+k in bits 8k+7:8k of `rspRdata`, and the bits above the item are 0.
- R7: With `reqSigned` = 1, a byte or halfword load fills the bits above the item with the item's top bit.
- R8: `rspValid` is a one-cycle pulse. It is asserted in the cycle right after the cycle in which the last bus response arrived.
- R9: `rspErr` is 1 when any beat of the request returned `busErr`. A split store whose first beat errs issues no second beat.
- R10: While `busValid` is high and `busReady` is low, `busValid` stays high and `busAddr`, `busBe`, `busWdata` and `busWrite` hold their values.
- R11: `reqReady` is 1 only when no request is in flight. It drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | CPU request valid |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address of the item |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqSigned | input | 1 | Sign-extend load result |
| reqWdata | input | 32 | Store data, right-justified |
| rspValid | output | 1 | One-cycle response pulse |
| rspRdata | output | 32 | Load result, right-justified |
| rspErr | output | 1 | A beat returned a bus error |
| busValid | output | 1 | Bus access request |
| busReady | input | 1 | Bus accepts the access |
| busWrite | output | 1 | Bus access is a write |
| busAddr | output | ADDR_W | Word-aligned bus address |
| busBe | output | 4 | Byte-lane enables |
| busWdata | output | 32 | Lane-aligned write data |
| busRspValid | input | 1 | Bus response for the accepted access |
| busRdata | input | 32 | Bus read data |
| busErr | input | 1 | Bus error for the response |

## Verification
On every cycle, the assertions check these properties:
- bus requests stay stable under back-pressure;
- every issued beat has nonzero enables;
- a second beat only ever belongs to a split request;
- a byte request is never split;
- the response is a single pulse;
- `reqReady` drops after acceptance;
- a bus error on a beat leads directly to the response.

Only the bench scenarios can show the rest:
- the exact beat addresses and enables for each offset and size;
- where store bytes land in memory, and that neighbouring bytes are untouched;
- how split load lanes are merged and sign-extended;
- that the response arrives exactly one cycle after the last bus response.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

  typedef enum logic [1:0] {
    StIdle  = 2'd0,
    StIssue = 2'd1,
    StWait  = 2'd2,
    StResp  = 2'd3
  } splitState_t;

  typedef struct packed {
    logic latchReq;       // capture the CPU request
    logic captureLow;     // hold lanes of the first beat
    logic captureResult;  // build the final response
    logic beatSel;        // 0 = lower word, 1 = next word
  } ctrlStrobes_t;

endpackage

// File: rtl/lsu_split_ctrl.sv
module lsu_split_ctrl
  import lsu_split_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         isSplit,
  input  logic         busReady,
  input  logic         busRspValid,
  input  logic         busErr,
  output logic         reqReady,
  output logic         busValid,
  output logic         rspValid,
  output ctrlStrobes_t strb
);

  splitState_t stateQ, stateD;
  logic beatQ, beatD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= StIdle;
      beatQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      beatQ  <= beatD;
    end
  end

  always_comb begin
    stateD = stateQ;
    beatD  = beatQ;
    strb   = '0;
    strb.beatSel = beatQ;
    reqReady = 1'b0;
    busValid = 1'b0;
    rspValid = 1'b0;
    unique case (stateQ)
      StIdle: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          beatD  = 1'b0;
          stateD = StIssue;
        end
      end
      StIssue: begin
        busValid = 1'b1;
        if (busReady) stateD = StWait;
      end
      StWait: begin
        if (busRspValid) begin
          if (!beatQ && isSplit && !busErr) begin
            strb.captureLow = 1'b1;
            beatD  = 1'b1;
            stateD = StIssue;
          end else begin
            strb.captureResult = 1'b1;
            stateD = StResp;
          end
        end
      end
      default: begin
        rspValid = 1'b1;
        stateD   = StIdle;
      end
    endcase
  end

  // R8
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R11
  req_ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R9
  err_ends_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == StWait && busRspValid && busErr) |=> (rspValid && !busValid));

endmodule

// File: rtl/lsu_split_dpath.sv
module lsu_split_dpath
  import lsu_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       busRdata,
  input  logic              busErr,
  output logic              isSplit,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busBe,
  output logic [31:0]       busWdata,
  output logic [31:0]       rspRdata,
  output logic              rspErr
);

  localparam int LANES   = 4;
  localparam int WORD_W  = 8 * LANES;
  localparam int OFF_W   = $clog2(LANES);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic              sgnQ, wrQ, errQ;
  logic [WORD_W-1:0] wdataQ, lowQ, resQ;

  logic [OFF_W-1:0]    off;
  logic [2*LANES-1:0]  sizeMask, laneMask;
  logic [2*WORD_W-1:0] wide, src, shifted;
  logic [WORD_W-1:0]   ext;
  logic [ADDR_W-OFF_W-1:0] wordIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0; sizeQ <= '0; sgnQ <= 1'b0; wrQ <= 1'b0;
      wdataQ <= '0; lowQ <= '0; resQ <= '0; errQ <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        sgnQ   <= reqSigned;
        wrQ    <= reqWrite;
        wdataQ <= reqWdata;
        errQ   <= 1'b0;
      end
      if (strb.captureLow) lowQ <= busRdata;
      if (strb.captureResult) begin
        resQ <= wrQ ? '0 : ext;
        errQ <= errQ | busErr;
      end
    end
  end

  always_comb begin
    off = addrQ[OFF_W-1:0];
    unique case (sizeQ)
      2'd0:    sizeMask = 8'b0000_0001;
      2'd1:    sizeMask = 8'b0000_0011;
      default: sizeMask = 8'b0000_1111;
    endcase
    laneMask = sizeMask << off;
    isSplit  = |laneMask[2*LANES-1:LANES];
  end

  always_comb begin
    wide    = {{WORD_W{1'b0}}, wdataQ} << {off, 3'b000};
    wordIdx = addrQ[ADDR_W-1:OFF_W] + {{(ADDR_W-OFF_W-1){1'b0}}, strb.beatSel};
    busAddr = {wordIdx, {OFF_W{1'b0}}};
    busBe    = strb.beatSel ? laneMask[2*LANES-1:LANES] : laneMask[LANES-1:0];
    busWdata = strb.beatSel ? wide[2*WORD_W-1:WORD_W] : wide[WORD_W-1:0];
    busWrite = wrQ;
  end

  always_comb begin
    src     = isSplit ? {busRdata, lowQ} : {{WORD_W{1'b0}}, busRdata};
    shifted = src >> {off, 3'b000};
    unique case (sizeQ)
      2'd0:    ext = {{24{sgnQ & shifted[7]}},  shifted[7:0]};
      2'd1:    ext = {{16{sgnQ & shifted[15]}}, shifted[15:0]};
      default: ext = shifted[WORD_W-1:0];
    endcase
  end

  assign rspRdata = resQ;
  assign rspErr   = errQ;

  // R3
  second_beat_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.beatSel |-> isSplit);

  // R4
  byte_never_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sizeQ == 2'd0) |-> !isSplit);

endmodule

// File: rtl/lsu_split_top.sv
module lsu_split_top
  import lsu_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  output logic              busValid,
  input  logic              busReady,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busBe,
  output logic [31:0]       busWdata,
  input  logic              busRspValid,
  input  logic [31:0]       busRdata,
  input  logic              busErr
);

  ctrlStrobes_t strb;
  logic         isSplit;

  lsu_split_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isSplit(isSplit),
    .busReady(busReady), .busRspValid(busRspValid), .busErr(busErr),
    .reqReady(reqReady), .busValid(busValid), .rspValid(rspValid), .strb(strb)
  );

  lsu_split_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqSigned(reqSigned),
    .reqWdata(reqWdata), .busRdata(busRdata), .busErr(busErr),
    .isSplit(isSplit), .busWrite(busWrite), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busBe)
                                 && $stable(busWdata) && $stable(busWrite)));

  // R2
  bus_be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> (busBe != 4'b0000));

endmodule

// File: tb/tb_lsu_split_top.sv
module tb_lsu_split_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 0, reqWrite = 0, reqSigned = 0;
  logic [31:0] reqAddr = 0, reqWdata = 0;
  logic [1:0]  reqSize = 0;
  logic        reqReady, rspValid, rspErr;
  logic [31:0] rspRdata;
  logic        busValid, busWrite, busReady, busRspValid, busErr;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [3:0]  busBe;

  lsu_split_top dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqSigned(reqSigned), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .rspErr(rspErr), .busValid(busValid),
    .busReady(busReady), .busWrite(busWrite), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRspValid(busRspValid),
    .busRdata(busRdata), .busErr(busErr)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  logic [7:0] mem [64];
  logic [7:0] snap [64];
  int nBeats = 0;
  int beatWord [2];
  logic [3:0] beatBe [2];
  int errWord = -1;
  int lastRspCyc = 0;
  int stallViol = 0;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Bus slave model: random ready, 0..2 cycle response delay
  initial begin
    logic pValid, pWrite, pend;
    logic [31:0] pAddr, pWdata;
    logic [3:0]  pBe;
    int dly, w;
    pValid = 0; pWrite = 0; pend = 0; pAddr = 0; pWdata = 0; pBe = 0; dly = 0;
    busReady = 0; busRspValid = 0; busErr = 0; busRdata = 0;
    forever begin
      @(negedge clk);
      busRspValid = 0; busErr = 0;
      if (!rst_n) begin
        busReady = 0; pend = 0; pValid = 0;
      end else begin
        if (pValid && !busReady && busValid &&
            (busAddr != pAddr || busBe != pBe || busWdata != pWdata || busWrite != pWrite))
          stallViol++;
        if (pValid && !pValid == 0 && busReady) begin
          w = int'(pAddr[31:2]);
          if (nBeats < 2) begin beatWord[nBeats] = w; beatBe[nBeats] = pBe; end
          nBeats++;
          busErr = 0;
          pend = 1;
          dly = $urandom % 3;
          busReady = 0;
          busRdata = {mem[(w*4+3)%64], mem[(w*4+2)%64], mem[(w*4+1)%64], mem[(w*4)%64]};
          if (pWrite && w != errWord)
            for (int k = 0; k < 4; k++)
              if (pBe[k]) mem[(w*4+k)%64] = pWdata[8*k +: 8];
        end
        if (pend) begin
          if (dly == 0) begin
            busRspValid = 1;
            busErr = (int'(pAddr[31:2]) == errWord);
            pend = 0;
            lastRspCyc = cyc;
          end else dly--;
        end
        busReady = pend ? 1'b0 : 1'($urandom % 2);
        pValid = busValid; pAddr = busAddr; pBe = busBe;
        pWdata = busWdata; pWrite = busWrite;
      end
    end
  end

  function automatic logic [7:0] fMask(int a, int sz);
    int nb = 1 << sz;
    return 8'(((1 << nb) - 1) << (a % 4));
  endfunction

  function automatic logic [31:0] fRead(int a, int sz, bit sg);
    logic [31:0] v = 0;
    int nb = 1 << sz;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = mem[a+k];
    if (sg && sz == 0) v = {{24{v[7]}}, v[7:0]};
    if (sg && sz == 1) v = {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic access(input bit wr, input int a, input int sz, input bit sg,
                        input logic [31:0] wd, input bit expErr, input int expNb);
    logic [31:0] expRd;
    logic [7:0]  m;
    bit split;
    int mism;
    m = fMask(a, sz);
    split = (m[7:4] != 0);
    expRd = fRead(a, sz, sg);
    for (int i = 0; i < 64; i++) snap[i] = mem[i];
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    nBeats = 0;
    reqValid = 1; reqWrite = wr; reqAddr = 32'(a); reqSize = 2'(sz);
    reqSigned = sg; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R11", "reqReady after accept", 64'(reqReady), 0);
    while (!rspValid) @(negedge clk);
    chk(cyc == lastRspCyc + 1, "R8", "response timing", 64'(cyc), 64'(lastRspCyc + 1));
    chk(rspErr == expErr, "R9", "rspErr", 64'(rspErr), 64'(expErr));
    if (expNb < 0) expNb = split ? 2 : 1;
    chk(nBeats == expNb, split ? "R3" : "R2", "beat count", 64'(nBeats), 64'(expNb));
    if (nBeats >= 1) begin
      chk(beatWord[0] == a / 4, "R2", "beat0 word", 64'(beatWord[0]), 64'(a / 4));
      chk(beatBe[0] == m[3:0], "R2", "beat0 enables", 64'(beatBe[0]), 64'(m[3:0]));
    end
    if (nBeats == 2) begin
      chk(beatWord[1] == a / 4 + 1, "R3", "beat1 word", 64'(beatWord[1]), 64'(a / 4 + 1));
      chk(beatBe[1] == m[7:4], "R3", "beat1 enables", 64'(beatBe[1]), 64'(m[7:4]));
    end
    if (!wr && !expErr)
      chk(rspRdata == expRd, sg ? "R7" : "R6", "load data", 64'(rspRdata), 64'(expRd));
    if (wr && !expErr) begin
      mism = 0;
      for (int i = 0; i < 64; i++)
        if (mem[i] !== ((i >= a && i < a + (1 << sz)) ? wd[8*(i-a) +: 8] : snap[i])) mism++;
      chk(mism == 0, "R5", "store bytes", 64'(mism), 0);
    end
    @(negedge clk);
    chk(!rspValid, "R8", "single pulse", 64'(rspValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(reqReady && !busValid && !rspValid, "R1", "reset state",
        {61'd0, reqReady, busValid, rspValid}, 64'b100);
    rst_n = 1;
    @(negedge clk);
    chk(reqReady && !busValid && !rspValid, "R1", "after reset",
        {61'd0, reqReady, busValid, rspValid}, 64'b100);

    // R5 R3 R6: word at offset 3, packed across words
    access(1, 7, 2, 0, 32'hA1B2C3D4, 0, -1);
    access(0, 7, 2, 0, 0, 0, -1);
    // R4: halfword at offset 3 splits, offset 2 does not
    access(1, 11, 1, 0, 32'h0000BEEF, 0, 2);
    access(1, 14, 1, 0, 32'h0000CAFE, 0, 1);
    access(0, 11, 1, 0, 0, 0, 2);
    // R4: byte at every offset, single beat
    for (int o = 0; o < 4; o++) access(1, 20 + o, 0, 0, 32'(8'h80 + o), 0, 1);
    // R7: signed byte and halfword
    access(0, 20, 0, 1, 0, 0, 1);
    access(0, 20, 1, 1, 0, 0, 1);
    access(0, 23, 1, 1, 0, 0, 2);
    access(0, 20, 1, 0, 0, 0, 1);
    // R4: word at offset 1 and 2 split, offset 0 does not
    access(0, 25, 2, 0, 0, 0, 2);
    access(0, 26, 2, 0, 0, 0, 2);
    access(0, 28, 2, 0, 0, 0, 1);
    // R9: first-beat error on split store -> one beat, no write
    errWord = 8;
    access(1, 33, 2, 0, 32'h11223344, 1, 1);
    chk(mem[33] == snap[33] && mem[36] == snap[36], "R9", "no store after error",
        {mem[33], mem[36]}, {snap[33], snap[36]});
    // R9: second-beat error on split load -> two beats, error
    errWord = 10;
    access(0, 38, 2, 0, 0, 1, 2);
    errWord = -1;

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int a, sz;
      a = $urandom % 56;
      sz = $urandom % 3;
      access(1'($urandom % 2), a, sz, 1'($urandom % 2), $urandom, 0, -1);
    end

    chk(stallViol == 0, "R10", "bus held under stall", 64'(stallViol), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule